// File: doc/BRIEF.md
# Video Controller Command Port Decoder

This block sits behind the command port of a tile-based video display controller. The host CPU writes 16-bit words to the port. Each word is one of three kinds:

- a single-word write to one of the controller's internal 8-bit configuration registers;
- the first half of a two-word memory-address setup;
- the second half of that setup.

The block assembles a 6-bit access code and a 16-bit access address from the two halves. It keeps the configuration register file, and it decodes the access code for the data-port path. The decode names the target memory (video RAM, colour RAM or vertical-scroll RAM), says whether the access is a read or a write, and says whether a DMA-class code has been loaded.

A read of the command port returns a status word assembled from externally supplied flags. The data-port path pulses a strobe after each transfer, and the block then advances the access address by a step held in one configuration register. DMA engines, the memories and rendering live elsewhere.

Top module: `cmdport_decoder`

## Requirements
- R1: After reset the access address is 0, the access code is 0, no second word is pending, and every configuration register holds 0.
- R2: A write with no second word pending whose bits 15..14 are `10` is a register write. Register number bits 12..8 select the register, and bits 7..0 are stored there. A register number of NUM_REGS or more changes nothing. Access address, access code and the pending flag are left unchanged.
- R3: A write with no second word pending whose bits 15..14 are not `10` is a first address word. Code bits 1..0 take word bits 15..14 and address bits 13..0 take word bits 13..0. Code bits 5..2 and address bits 15..14 keep their values, and a second word becomes pending.
- R4: While a second word is pending, the next write is always taken as the second word, whatever its top bits. Code bits 5..2 take word bits 7..4 and address bits 15..14 take word bits 1..0. The pending flag then clears.
- R5: The status output equals the 10 status flags in bits 9..0 with bits 15..10 zero. The flags are, from bit 9 down: FIFO empty, FIFO full, vertical interrupt pending, sprite overflow, sprite collision, odd frame, vertical blank, horizontal blank, DMA busy, PAL mode.
- R6: A status read with no write in the same cycle clears the pending flag. When a read and a write coincide, the write is processed and the read has no effect on the pending flag.
- R7: Code bits 3..0 select the target. The target encoding is 0 none, 1 video RAM, 2 colour RAM, 3 scroll RAM.
  - `0001` is a video RAM write and `0000` a video RAM read.
  - `0011` is a colour RAM write and `1000` a colour RAM read.
  - `0101` is a scroll RAM write and `0100` a scroll RAM read.
  - Any other value gives target 0 and clears the valid flag.
  - The write flag equals code bit 0 for a valid target and is 0 otherwise.
- R8: The DMA flag equals code bit 5. The copy flag is set only when code bits 5 and 4 are both 1.
- R9: A data-access strobe with no command write in the same cycle adds the 8-bit value of register INC_REG (default 15) to the access address, modulo 2^16. A strobe in the same cycle as a command write is ignored.
- R10: The register read-out returns the register selected by `reg_sel`, or 0 when `reg_sel` is NUM_REGS or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command-port write strobe |
| cmd_wdata | input | 16 | Command-port write word |
| cmd_rd | input | 1 | Command-port status read strobe |
| stat_flags | input | 10 | Status flags, bit 9 FIFO empty down to bit 0 PAL |
| status_rdata | output | 16 | Status word |
| data_acc | input | 1 | Data-port transfer done strobe |
| reg_sel | input | 5 | Register read-out select |
| reg_val | output | 8 | Selected register value |
| acc_addr | output | 16 | Current access address |
| acc_code | output | 6 | Current access code |
| second_pending | output | 1 | A second address word is awaited |
| tgt_mem | output | 2 | Target memory (0 none, 1 VRAM, 2 CRAM, 3 scroll RAM) |
| tgt_write | output | 1 | Access is a write |
| tgt_valid | output | 1 | Code names a legal target |
| dma_req | output | 1 | DMA-class code loaded |
| dma_copy | output | 1 | DMA copy code loaded |

## Verification
The hardest situation to reach is a word whose top bits are `10` arriving while a second word is pending. It looks like a register write, but it must be taken as address data. The stimulus builds it deliberately: it sends a first word and then follows it with such a word. It also places status reads and data strobes in the same cycle as command writes, to exercise the priority rules. Address wrap-around is reached by loading an address near 0xFFFF before stepping it.

// File: rtl/cmdport_pkg.sv
package cmdport_pkg;
    typedef enum logic [1:0] {
        MEM_NONE  = 2'd0,
        MEM_VRAM  = 2'd1,
        MEM_CRAM  = 2'd2,
        MEM_VSRAM = 2'd3
    } mem_sel_e;

    typedef enum logic [1:0] {
        WORD_REG    = 2'd0,
        WORD_FIRST  = 2'd1,
        WORD_SECOND = 2'd2
    } word_kind_e;

    localparam int CODE_W = 6;
    localparam int ADDR_W = 16;
endpackage

// File: rtl/cmdport_classify.sv
module cmdport_classify
    import cmdport_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              pend,
    input  logic [WORD_W-1:0] word,
    output word_kind_e        kind
);
    always_comb begin
        if (pend)
            kind = WORD_SECOND;
        else if (word[WORD_W-1 -: 2] == 2'b10)
            kind = WORD_REG;
        else
            kind = WORD_FIRST;
    end
endmodule

// File: rtl/cmdport_target_decode.sv
module cmdport_target_decode
    import cmdport_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output mem_sel_e          mem,
    output logic              wr,
    output logic              valid,
    output logic              dma,
    output logic              copy
);
    always_comb begin
        mem = MEM_NONE;
        unique case (code[3:0])
            4'b0001, 4'b0000: mem = MEM_VRAM;
            4'b0011, 4'b1000: mem = MEM_CRAM;
            4'b0101, 4'b0100: mem = MEM_VSRAM;
            default:          mem = MEM_NONE;
        endcase
        valid = (mem != MEM_NONE);
        wr    = valid & code[0];
        dma   = code[5];
        copy  = code[5] & code[4];
    end
endmodule

// File: rtl/cmdport_decoder.sv
module cmdport_decoder
    import cmdport_pkg::*;
#(
    parameter int NUM_REGS  = 24,
    parameter int INC_REG   = 15,
    parameter int FLAG_W    = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_wr,
    input  logic [15:0]          cmd_wdata,
    input  logic                 cmd_rd,
    input  logic [FLAG_W-1:0]    stat_flags,
    output logic [15:0]          status_rdata,
    input  logic                 data_acc,
    input  logic [4:0]           reg_sel,
    output logic [7:0]           reg_val,
    output logic [ADDR_W-1:0]    acc_addr,
    output logic [CODE_W-1:0]    acc_code,
    output logic                 second_pending,
    output logic [1:0]           tgt_mem,
    output logic                 tgt_write,
    output logic                 tgt_valid,
    output logic                 dma_req,
    output logic                 dma_copy
);
    localparam int IDX_W = 5;
    localparam int LO_W  = 14;

    typedef struct packed {
        logic [NUM_REGS-1:0][7:0] regs;
        logic [ADDR_W-1:0]        addr;
        logic [CODE_W-1:0]        code;
        logic                     pend;
    } state_t;

    state_t     st_d, st_q;
    word_kind_e kind;
    mem_sel_e   mem;
    logic [IDX_W-1:0] wr_idx;

    assign wr_idx = cmd_wdata[8 +: IDX_W];

    cmdport_classify #(.WORD_W(16)) u_classify (
        .pend (st_q.pend),
        .word (cmd_wdata),
        .kind (kind)
    );

    cmdport_target_decode u_decode (
        .code  (st_q.code),
        .mem   (mem),
        .wr    (tgt_write),
        .valid (tgt_valid),
        .dma   (dma_req),
        .copy  (dma_copy)
    );

    always_comb begin
        st_d = st_q;
        if (cmd_wr) begin
            unique case (kind)
                WORD_REG: begin
                    for (int i = 0; i < NUM_REGS; i++)
                        if (wr_idx == IDX_W'(i))
                            st_d.regs[i] = cmd_wdata[7:0];
                end
                WORD_FIRST: begin
                    st_d.code[1:0]      = cmd_wdata[15:14];
                    st_d.addr[LO_W-1:0] = cmd_wdata[LO_W-1:0];
                    st_d.pend           = 1'b1;
                end
                default: begin
                    st_d.code[5:2]          = cmd_wdata[7:4];
                    st_d.addr[ADDR_W-1:LO_W] = cmd_wdata[1:0];
                    st_d.pend               = 1'b0;
                end
            endcase
        end else begin
            if (data_acc)
                st_d.addr = st_q.addr + {8'h00, st_q.regs[INC_REG]};
            if (cmd_rd)
                st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        reg_val = 8'h00;
        for (int i = 0; i < NUM_REGS; i++)
            if (reg_sel == IDX_W'(i))
                reg_val = st_q.regs[i];
    end

    assign status_rdata   = {{(16-FLAG_W){1'b0}}, stat_flags};
    assign acc_addr       = st_q.addr;
    assign acc_code       = st_q.code;
    assign second_pending = st_q.pend;
    assign tgt_mem        = mem;
endmodule

// File: rtl/cmdport_decoder_chk.sv
module cmdport_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr,
    input logic [15:0] cmd_wdata,
    input logic        cmd_rd,
    input logic        data_acc,
    input logic [15:0] acc_addr,
    input logic [5:0]  acc_code,
    input logic        second_pending,
    input logic        tgt_valid,
    input logic        tgt_write
);
    AST_FIRST_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !second_pending && cmd_wdata[15:14] != 2'b10) |=> second_pending); // R3
    AST_SECOND_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && second_pending) |=> !second_pending); // R4
    AST_SECOND_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && second_pending) |=> acc_code[5:2] == $past(cmd_wdata[7:4])); // R4
    AST_READ_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd && !cmd_wr) |=> !second_pending); // R6
    AST_REGWR_KEEPS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !second_pending && cmd_wdata[15:14] == 2'b10)
        |=> ($stable(acc_addr) && $stable(acc_code) && !second_pending)); // R2
    AST_ADDR_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_wr && !data_acc) |=> $stable(acc_addr)); // R9
    AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_write |-> tgt_valid); // R7
endmodule

bind cmdport_decoder cmdport_decoder_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_wr         (cmd_wr),
    .cmd_wdata      (cmd_wdata),
    .cmd_rd         (cmd_rd),
    .data_acc       (data_acc),
    .acc_addr       (acc_addr),
    .acc_code       (acc_code),
    .second_pending (second_pending),
    .tgt_valid      (tgt_valid),
    .tgt_write      (tgt_write)
);

// File: tb/tb_cmdport_decoder.sv
module tb_cmdport_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic        cmd_rd = 1'b0;
    logic [9:0]  stat_flags = '0;
    logic [15:0] status_rdata;
    logic        data_acc = 1'b0;
    logic [4:0]  reg_sel = '0;
    logic [7:0]  reg_val;
    logic [15:0] acc_addr;
    logic [5:0]  acc_code;
    logic        second_pending;
    logic [1:0]  tgt_mem;
    logic        tgt_write, tgt_valid, dma_req, dma_copy;

    always #2 clk = ~clk;

    cmdport_decoder dut (.*);

    int vectors = 0;
    int fails   = 0;
    int m_regs[32];
    int m_addr, m_code, m_pend;

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_mem(int c);
        case (c & 15)
            1, 0:  return 1;
            3, 8:  return 2;
            5, 4:  return 3;
            default: return 0;
        endcase
    endfunction

    task automatic compare_all();
        int v = (exp_mem(m_code) != 0) ? 1 : 0;
        chk("R3/R4 acc_addr", int'(acc_addr), m_addr);
        chk("R3/R4 acc_code", int'(acc_code), m_code);
        chk("R6 second_pending", int'(second_pending), m_pend);
        chk("R7 tgt_mem", int'(tgt_mem), exp_mem(m_code));
        chk("R7 tgt_valid", int'(tgt_valid), v);
        chk("R7 tgt_write", int'(tgt_write), v & (m_code & 1));
        chk("R8 dma_req", int'(dma_req), (m_code >> 5) & 1);
        chk("R8 dma_copy", int'(dma_copy), ((m_code >> 5) & (m_code >> 4)) & 1);
        chk("R5 status", int'(status_rdata), int'(stat_flags));
        chk("R10 reg_val", int'(reg_val), (reg_sel < 24) ? m_regs[reg_sel] : 0);
    endtask

    // Drive inputs at a falling edge, update the model, wait one rising edge.
    task automatic step(bit w, int wd, bit r, bit acc, int flags, int sel);
        cmd_wr = w; cmd_wdata = 16'(wd); cmd_rd = r; data_acc = acc;
        stat_flags = 10'(flags); reg_sel = 5'(sel);
        #1 compare_all();
        if (w) begin
            if (m_pend == 1) begin
                m_code = (m_code & 3) | (((wd >> 4) & 15) << 2);
                m_addr = (m_addr & 16'h3FFF) | ((wd & 3) << 14);
                m_pend = 0;
            end else if (((wd >> 14) & 3) == 2) begin
                if (((wd >> 8) & 31) < 24) m_regs[(wd >> 8) & 31] = wd & 255;
            end else begin
                m_code = (m_code & 60) | ((wd >> 14) & 3);
                m_addr = (m_addr & 16'hC000) | (wd & 16'h3FFF);
                m_pend = 1;
            end
        end else begin
            if (acc) m_addr = (m_addr + m_regs[15]) & 16'hFFFF;
            if (r) m_pend = 0;
        end
        @(negedge clk);
    endtask

    task automatic idle(int sel);
        step(0, 0, 0, 0, 10'h2A5, sel);
    endtask

    task automatic setup(int code, int addr);
        step(1, ((code & 3) << 14) | (addr & 16'h3FFF), 0, 0, 0, 15);
        step(1, (((code >> 2) & 15) << 4) | ((addr >> 14) & 3), 0, 0, 0, 15);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int codes[8] = '{1, 3, 5, 0, 8, 4, 33, 48};
        for (int i = 0; i < 32; i++) m_regs[i] = 0;
        m_addr = 0; m_code = 0; m_pend = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        idle(15);
        for (int i = 0; i < 24; i++) idle(i);
        // R2: register writes, step register, out-of-range index ignored
        step(1, 16'h8F02, 0, 0, 0, 15);
        step(1, 16'h8301, 0, 0, 0, 3);
        step(1, 16'h9E55, 0, 0, 0, 30);
        idle(30);
        idle(3);
        // R3/R4/R7/R8: every target code and DMA codes
        foreach (codes[k]) begin
            setup(codes[k], 16'h1234 + k * 16'h4111);
            idle(15);
        end
        // R9: address stepping and wrap
        setup(1, 16'hFFFD);
        step(0, 0, 0, 1, 0, 15);
        step(0, 0, 0, 1, 0, 15);
        idle(15);
        // R9: strobe ignored alongside a command write
        step(1, 16'h4000, 0, 1, 0, 15);
        step(1, 16'h0000, 0, 1, 0, 15);
        // R4: register-looking word while pending is the second word
        step(1, 16'h4055, 0, 0, 0, 15);
        step(1, 16'h8072, 0, 0, 0, 0);
        idle(0);
        // R6: status read clears pending; read with a write loses
        step(1, 16'h0100, 0, 0, 10'h3FF, 15);
        step(0, 0, 1, 0, 10'h200, 15);
        step(1, 16'h0200, 1, 0, 10'h001, 15);
        idle(15);
        step(1, 16'h0030, 1, 0, 10'h155, 15);
        // R5: status under several flag patterns
        for (int i = 0; i < 10; i++) step(0, 0, 1, 0, 1 << i, 15);
        idle(15);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule